// File: doc/BRIEF.md
# Shared Address/Data and General-Purpose Port Controller

This block controls one port of pins that serve either as an external multiplexed address/data bus or as general-purpose I/O. Each pin is represented as four digital enables rather than an analog pad: a high-side driver, a low-side driver, a weak pull-up and a medium pull-up. A port-wide select bit chooses whether the pins follow the bus or a software output register. In I/O mode a second port-wide bit chooses between push-pull and open-drain drive.

The level on every pin is sampled through a two-flop synchronizer into a pin register that software reads back. In open-drain mode with an output bit at 1, the pin floats and acts as an input. The readback then shows which pins the port itself pulls low and which an external device drives. While reset is held, only the weak pull-up is active. For a fixed number of cycles after reset is released, the medium pull-up helps the pin rise.

Top module: `mux_port_ctl`

## Requirements
- R1: While `rst_n` is 0, `drv_hi` and `drv_lo` are all zero and `pu_weak` is all ones, whatever the register contents. When `rst_n` is 1, `pu_weak` is all zeros.
- R2: Reset sets the output register to all ones and the control register to select 1 and drive-mode 0. These values are readable: `rd_addr`=1 returns the output register, and `rd_addr`=2 returns the control register with bit 0 as select and bit 1 as drive-mode.
- R3: With select 0 and `bus_oe` 1, `drv_hi` equals `bus_data` and `drv_lo` equals its inverse. The output register has no effect in this case.
- R4: With select 0 and `bus_oe` 0, both drivers are off on every pin.
- R5: With select 1 and drive-mode 1 (push-pull), `drv_hi` equals the output register and `drv_lo` equals its inverse.
- R6: With select 1 and drive-mode 0 (open-drain), `drv_hi` is all zeros and `drv_lo` is the inverse of the output register. A bit at 1 leaves its pin undriven, so the pin can serve as an input.
- R7: No pin ever has `drv_hi` and `drv_lo` on together.
- R8: `rd_addr`=0 returns `pin_in` as it was two rising edges earlier. It does not return the output register.
- R9: `pu_med` is 1 from the release of reset for PULL_CYCLES rising edges, then 0. It stays 0 until the next reset.
- R10: When `wr_en` is 1, a write takes effect at the next rising edge. `wr_addr` 0 writes the output register. `wr_addr` 1 writes the control register from `wr_data[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 output register, 1 control |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Read target: 0 pins, 1 output register, 2 control |
| rd_data | output | WIDTH | Read data |
| bus_data | input | WIDTH | Address/data value to drive in bus mode |
| bus_oe | input | 1 | Bus drives the pins when 1 |
| pin_in | input | WIDTH | Resolved pin levels |
| drv_hi | output | WIDTH | High-side driver enables |
| drv_lo | output | WIDTH | Low-side driver enables |
| pu_weak | output | WIDTH | Weak pull-up enables |
| pu_med | output | 1 | Medium pull-up enable, shared by the port |

## Verification
The hardest state to reach from the ports is a reset that arrives while the port is actively driving. The registers hold push-pull mode with low outputs, and reset must still cut both drivers and restore the register defaults. The bench sets up exactly that configuration, asserts reset mid-run and then reads the registers back. The two-edge readback delay is also awkward to observe. The bench holds the pins steady, changes them half a cycle before an edge, and samples after the first edge and again after the second.

// File: rtl/mux_port_ctl.sv
module mux_port_ctl #(
  parameter int WIDTH       = 8,
  parameter int PULL_CYCLES = 75
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] bus_data,
  input  logic             bus_oe,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] drv_hi,
  output logic [WIDTH-1:0] drv_lo,
  output logic [WIDTH-1:0] pu_weak,
  output logic             pu_med
);
  localparam int CW = $clog2(PULL_CYCLES + 1);

  logic [WIDTH-1:0] out_q, sync1_q, sync2_q;
  logic             io_sel_q, push_q;
  logic [CW-1:0]    pull_cnt_q;
  logic [1:0]       settle_q;
  logic [WIDTH-1:0] hi_raw, lo_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '1;
      io_sel_q <= 1'b1;
      push_q   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr) begin
        io_sel_q <= wr_data[0];
        push_q   <= wr_data[1];
      end else begin
        out_q <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q  <= '0;
      sync2_q  <= '0;
      settle_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pull_cnt_q <= CW'(PULL_CYCLES);
    else if (pull_cnt_q != '0) pull_cnt_q <= pull_cnt_q - CW'(1);
  end

  assign hi_raw = io_sel_q ? (out_q & {WIDTH{push_q}}) : (bus_data & {WIDTH{bus_oe}});
  assign lo_raw = io_sel_q ? ~out_q : (~bus_data & {WIDTH{bus_oe}});

  assign drv_hi  = hi_raw & {WIDTH{rst_n}};
  assign drv_lo  = lo_raw & {WIDTH{rst_n}};
  assign pu_weak = {WIDTH{~rst_n}};
  assign pu_med  = rst_n && (pull_cnt_q != '0);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = sync2_q;
      2'd1:    rd_data = out_q;
      2'd2:    rd_data = {{(WIDTH-2){1'b0}}, push_q, io_sel_q};
      default: rd_data = '0;
    endcase
  end

  always_comb begin
    if (!rst_n) begin
      assert_reset_hold_R1: assert (drv_hi == '0 && drv_lo == '0 && pu_weak == '1);
    end
  end

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_hi & drv_lo) == '0);

  assert_open_drain_hi_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_sel_q && !push_q) |-> drv_hi == '0);

  assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_q >= 2'd2) |-> sync2_q == $past(pin_in, 2));

  assert_med_stays_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pu_med |=> !pu_med);
endmodule

// File: tb/mux_port_ctl_tb_top.sv
`timescale 1ns/1ps
module mux_port_ctl_tb_top;
  localparam int W = 8;
  localparam int N = 75;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_addr = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [1:0]   rd_addr = 2'd0;
  logic [W-1:0] rd_data;
  logic [W-1:0] bus_data = '0;
  logic         bus_oe = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] drv_hi, drv_lo, pu_weak;
  logic         pu_med;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mux_port_ctl #(.WIDTH(W), .PULL_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .bus_data(bus_data), .bus_oe(bus_oe),
    .pin_in(pin_in), .drv_hi(drv_hi), .drv_lo(drv_lo), .pu_weak(pu_weak), .pu_med(pu_med)
  );

  // {ctrl[1:0], port[7:0], bus[7:0], oe, exp_hi[7:0], exp_lo[7:0]}
  localparam int NV = 7;
  localparam logic [34:0] VEC [NV] = '{
    {2'b01, 8'hA5, 8'h00, 1'b0, 8'h00, 8'h5A},
    {2'b11, 8'hA5, 8'h00, 1'b0, 8'hA5, 8'h5A},
    {2'b00, 8'hA5, 8'h3C, 1'b1, 8'h3C, 8'hC3},
    {2'b00, 8'hA5, 8'h3C, 1'b0, 8'h00, 8'h00},
    {2'b10, 8'hFF, 8'hF0, 1'b1, 8'hF0, 8'h0F},
    {2'b01, 8'hFF, 8'h55, 1'b1, 8'h00, 8'h00},
    {2'b11, 8'h00, 8'h55, 1'b0, 8'h00, 8'hFF}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset drivers hi", drv_hi, 8'h00);
    check("R1 reset drivers lo", drv_lo, 8'h00);
    check("R1 reset weak pull-up", pu_weak, 8'hFF);
    check("R9 med off in reset", {7'b0, pu_med}, 8'h00);

    rst_n = 1'b1;
    #0.1;
    check("R9 med on at release", {7'b0, pu_med}, 8'h01);
    check("R1 weak off after release", pu_weak, 8'h00);
    repeat (N - 1) @(negedge clk);
    check("R9 med on before window ends", {7'b0, pu_med}, 8'h01);
    @(negedge clk);
    check("R9 med off after window", {7'b0, pu_med}, 8'h00);

    rd_addr = 2'd1; #0.1;
    check("R2 output reg reset", rd_data, 8'hFF);
    rd_addr = 2'd2; #0.1;
    check("R2 control reg reset", rd_data, 8'h01);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] c;
      string tag;
      c = VEC[i][34:33];
      wr(1'b1, {6'b0, c});
      wr(1'b0, VEC[i][32:25]);
      bus_data = VEC[i][24:17];
      bus_oe   = VEC[i][16];
      @(negedge clk);
      tag = c[0] ? (c[1] ? "R5" : "R6") : (bus_oe ? "R3" : "R4");
      check({tag, " drv_hi"}, drv_hi, VEC[i][15:8]);
      check({tag, " drv_lo"}, drv_lo, VEC[i][7:0]);
      check("R7 no contention", drv_hi & drv_lo, 8'h00);
    end

    // R10: write visible only after the edge
    wr(1'b0, 8'h3C);
    rd_addr = 2'd1;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'hC9;
    #0.1;
    check("R10 before edge", rd_data, 8'h3C);
    @(negedge clk);
    wr_en = 1'b0;
    check("R10 after edge", rd_data, 8'hC9);
    wr(1'b1, 8'hFE);
    rd_addr = 2'd2; #0.1;
    check("R10 control uses bits 1:0", rd_data, 8'h02);

    // R8: two-edge readback of pins, open-drain input use
    wr(1'b1, 8'h01);
    wr(1'b0, 8'hF0);
    pin_in = 8'h00;
    rd_addr = 2'd0;
    repeat (3) @(negedge clk);
    check("R8 settled pins", rd_data, 8'h00);
    pin_in = 8'hA0;
    @(negedge clk);
    check("R8 one edge old value", rd_data, 8'h00);
    @(negedge clk);
    check("R8 two edges new value", rd_data, 8'hA0);
    check("R6 released bits undriven", drv_lo, 8'h0F);
    check("R9 med stays off", {7'b0, pu_med}, 8'h00);

    // R1/R2: reset while actively driving
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h00);
    check("R5 driving low before reset", drv_lo, 8'hFF);
    @(negedge clk);
    rst_n = 1'b0;
    #0.1;
    check("R1 reset cuts hi", drv_hi, 8'h00);
    check("R1 reset cuts lo", drv_lo, 8'h00);
    check("R1 reset weak on", pu_weak, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    rd_addr = 2'd1; #0.1;
    check("R2 output reg restored", rd_data, 8'hFF);
    rd_addr = 2'd2; #0.1;
    check("R2 control restored", rd_data, 8'h01);
    check("R9 med on again", {7'b0, pu_med}, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule